// File: doc/BRIEF.md
# ADC Serial Port Device Model

This block models the device side of the 16-clock serial port of a multichannel bipolar analog-to-digital converter. A host controls it through a low-active chip select, a serial clock and a serial data input. Each frame returns a channel tag, a sign bit and a 12-bit magnitude field on a data output that the model releases whenever no frame is driving it. While a frame runs, the model also decodes a command shifted in on the data input and may write one of four internal registers.

The model is synchronous to a fast system clock. Chip select, serial clock and data input are sampled on that clock, and their edges are found by comparing each sample with the previous one. No analog path exists. The result for a frame is the `sample_value` input, captured when chip select falls. A hold flag shows when the sample-and-hold would be holding. All four registers and the current channel number are visible on a parallel debug port.

The different commit points of the registers are the point of the model. A frame that is cut short by an early rise of chip select still commits an auxiliary register if it ran past the 11th falling edge. It commits the control register only if it ran past the 15th.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `dout_oe` and `hold` are 0, all four registers read 0, and `cur_chan` is 0.
- R2: A falling `cs_n` sets `hold` and `dout_oe`, and drives `dout` with the most significant bit of the channel tag. The channel tag is the value of `cur_chan` at that moment.
- R3: The returned frame is 16 bits, sent most significant first: the 3-bit channel tag, then bit 12 of the captured sample (the sign), then sample bits 11 down to 0. After the k-th falling edge of `sclk` (k = 1..15), `dout` carries frame bit k, counted from 0 at the most significant end.
- R4: On the 16th falling edge of `sclk`, `dout_oe` goes to 0. While `dout_oe` is 0, `dout` reads 0.
- R5: `hold` stays at 1 until the 14th rising edge of `sclk` in the frame, and goes to 0 on that edge.
- R6: A rise of `cs_n` clears `dout_oe` and `hold`. If it comes before the 16th falling edge, the frame is aborted and `cur_chan` does not advance.
- R7: `din` is sampled on falling edges of `sclk`. The first bit is a write flag, where 1 means write. The next two bits, first bit more significant, select the register: 00 control, 01 sequence, 10 range A, 11 range B. A write flag of 0 changes no register.
- R8: The 12-bit control register takes `din` bits 4 to 15 of the frame, most significant first. It is written on the 15th falling edge. A frame that ends before that edge leaves it unchanged.
- R9: The 8-bit sequence, range A and range B registers take `din` bits 4 to 11, most significant first. They are written on the 11th falling edge. The write stands even if the frame is aborted afterwards, and a frame that ends before that edge leaves them unchanged.
- R10: Each completed frame (16 falling edges) advances `cur_chan` by one, modulo 8.
- R11: After the 16th falling edge, further `sclk` edges while `cs_n` stays low do not drive `dout_oe` and do not write any register.
- R12: The sample is captured when `cs_n` falls. Changes on `sample_value` during the frame do not change the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; a falling edge starts a frame |
| sclk | input | 1 | Serial clock, idle high |
| din | input | 1 | Serial command and write data |
| sample_value | input | 13 | Two's-complement sample (bit 12 is the sign) |
| dout | output | 1 | Serial result data; reads 0 while released |
| dout_oe | output | 1 | Enable of the three-state output driver |
| hold | output | 1 | 1 while the sample-and-hold is holding |
| ctrl_reg | output | 12 | Debug view of the control register |
| seq_reg | output | 8 | Debug view of the sequence register |
| range_a_reg | output | 8 | Debug view of range register A |
| range_b_reg | output | 8 | Debug view of range register B |
| cur_chan | output | 3 | Debug view of the channel counter |

## Verification
Every pin change becomes visible on the outputs at the first rising system-clock edge after it. This holds for `dout`, `dout_oe`, `hold` and the register contents. The bench changes one pin at a falling clock edge and reads the outputs at the next falling edge, exactly one register stage later. Register and channel results are read after chip select rises, by which point every commit that is due has happened. The random frames vary the abort point, the command and the extra clocks after the frame, and bench functions predict the frame word and the register contents on their own.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'b00,
    SEL_SEQ     = 2'b01,
    SEL_RANGE_A = 2'b10,
    SEL_RANGE_B = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    reg_sel_e sel;
  } cmd_t;

endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det #(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/sp_frame_ctrl.sv
module sp_frame_ctrl #(
  parameter int FRAME_LEN  = 16,
  parameter int TRACK_RISE = 14,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_cs_fall,
  input  logic             ev_cs_rise,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  output logic             ev_data_fall,
  output logic             ev_frame_done,
  output logic [CNT_W-1:0] fall_idx,
  output logic             hold,
  output logic             dout_oe
);
  logic             active_q;
  logic [CNT_W-1:0] fall_cnt_q;
  logic [CNT_W-1:0] rise_cnt_q;
  logic             hold_q;
  logic             oe_q;
  logic             ev_data_rise;
  logic             ev_track;
  logic             last_fall;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign ev_data_fall  = sclk_fall & active_q & ~ev_cs_rise & ~ev_cs_fall;
  assign ev_data_rise  = sclk_rise & active_q & ~ev_cs_rise & ~ev_cs_fall;
  assign fall_idx      = step(fall_cnt_q);
  assign last_fall     = (fall_idx == CNT_W'(FRAME_LEN));
  assign ev_frame_done = ev_data_fall & last_fall;
  assign ev_track      = ev_data_rise & (step(rise_cnt_q) == CNT_W'(TRACK_RISE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
      hold_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else if (ev_cs_fall) begin
      active_q   <= 1'b1;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
      hold_q     <= 1'b1;
      oe_q       <= 1'b1;
    end else if (ev_cs_rise) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (ev_data_fall) begin
        fall_cnt_q <= fall_idx;
        if (last_fall) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
        end
      end
      if (ev_data_rise) begin
        rise_cnt_q <= step(rise_cnt_q);
        if (ev_track) hold_q <= 1'b0;
      end
    end
  end

  assign hold    = hold_q;
  assign dout_oe = oe_q;

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_fall |=> (hold_q && oe_q)); // R2
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |=> !oe_q); // R4
  AST_HOLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(ev_track || ev_cs_rise)); // R5
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_rise |=> (!oe_q && !hold_q)); // R6
  AST_NO_LATE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !ev_cs_fall) |=> ($stable(fall_cnt_q) && !oe_q)); // R11
endmodule

// File: rtl/sp_reg_file.sv
module sp_reg_file
  import adc_sp_pkg::*;
#(
  parameter int CTRL_W = 12,
  parameter int AUX_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cs_fall,
  input  logic              ev_data_fall,
  input  logic [CNT_W-1:0]  fall_idx,
  input  logic              din,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [AUX_W-1:0]  seq_reg,
  output logic [AUX_W-1:0]  range_a_reg,
  output logic [AUX_W-1:0]  range_b_reg
);
  localparam int ADDR_BITS   = $bits(cmd_t);
  localparam int CTRL_COMMIT = ADDR_BITS + CTRL_W;
  localparam int AUX_COMMIT  = ADDR_BITS + AUX_W;

  logic [ADDR_BITS-1:0] addr_q;
  logic [CTRL_W-2:0]    data_sh_q;
  logic [CTRL_W-1:0]    data_nxt;
  cmd_t                 cmd;
  logic                 in_addr;
  logic                 ev_commit_ctrl;
  logic                 ev_commit_aux;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [AUX_W-1:0]     aux_q [3];

  function automatic logic at_edge(input logic [CNT_W-1:0] idx, input int n);
    return idx == CNT_W'(n);
  endfunction

  assign cmd      = cmd_t'(addr_q);
  assign in_addr  = (fall_idx <= CNT_W'(ADDR_BITS));
  assign data_nxt = {data_sh_q, din};

  assign ev_commit_ctrl = ev_data_fall & at_edge(fall_idx, CTRL_COMMIT) &
                          cmd.wr & (cmd.sel == SEL_CTRL);
  assign ev_commit_aux  = ev_data_fall & at_edge(fall_idx, AUX_COMMIT) &
                          cmd.wr & (cmd.sel != SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      data_sh_q <= '0;
    end else if (ev_cs_fall) begin
      addr_q    <= '0;
      data_sh_q <= '0;
    end else if (ev_data_fall) begin
      if (in_addr) addr_q    <= {addr_q[ADDR_BITS-2:0], din};
      else         data_sh_q <= data_nxt[CTRL_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrl_q <= '0;
    else if (ev_commit_ctrl) ctrl_q <= data_nxt;
  end

  for (genvar g = 0; g < 3; g++) begin : g_aux
    localparam reg_sel_e MY_SEL = reg_sel_e'(g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 aux_q[g] <= '0;
      else if (ev_commit_aux && cmd.sel == MY_SEL) aux_q[g] <= data_nxt[AUX_W-1:0];
    end
  end

  assign ctrl_reg    = ctrl_q;
  assign seq_reg     = aux_q[0];
  assign range_a_reg = aux_q[1];
  assign range_b_reg = aux_q[2];

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_commit_ctrl, ev_commit_aux})); // R7
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit_ctrl |=> $stable(ctrl_q)); // R8
  AST_AUX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit_aux |=> ($stable(aux_q[0]) && $stable(aux_q[1]) && $stable(aux_q[2]))); // R9
endmodule

// File: rtl/sp_tx_path.sv
module sp_tx_path #(
  parameter int ID_W      = 3,
  parameter int RES_W     = 12,
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_cs_fall,
  input  logic             ev_data_fall,
  input  logic             ev_frame_done,
  input  logic [CNT_W-1:0] fall_idx,
  input  logic [RES_W:0]   sample_value,
  output logic             dout_bit,
  output logic [ID_W-1:0]  chan
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] word_q;
  logic [FRAME_LEN-1:0] fresh;
  logic                 dout_q;
  logic [ID_W-1:0]      chan_q;

  function automatic logic [FRAME_LEN-1:0] pack_frame(input logic [ID_W-1:0] c,
                                                      input logic [RES_W:0] s);
    return {c, s};
  endfunction

  function automatic logic pick_bit(input logic [FRAME_LEN-1:0] w,
                                    input logic [CNT_W-1:0] idx);
    logic [IDX_W-1:0] pos;
    pos = IDX_W'(FRAME_LEN - 1) - IDX_W'(idx);
    return w[pos];
  endfunction

  function automatic logic [ID_W-1:0] next_chan(input logic [ID_W-1:0] c);
    return c + ID_W'(1);
  endfunction

  assign fresh = pack_frame(chan_q, sample_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dout_q <= 1'b0;
      chan_q <= '0;
    end else begin
      if (ev_cs_fall) begin
        word_q <= fresh;
        dout_q <= fresh[FRAME_LEN-1];
      end else if (ev_data_fall && fall_idx < CNT_W'(FRAME_LEN)) begin
        dout_q <= pick_bit(word_q, fall_idx);
      end
      if (ev_frame_done) chan_q <= next_chan(chan_q);
    end
  end

  assign dout_bit = dout_q;
  assign chan     = chan_q;

  AST_FIRST_TAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_fall |=> (dout_q == $past(chan_q[ID_W-1]))); // R2
  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |=> (chan_q == next_chan($past(chan_q)))); // R10
  AST_CHAN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_frame_done |=> $stable(chan_q)); // R6
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int ID_W       = 3,
  parameter int RES_W      = 12,
  parameter int CTRL_W     = 12,
  parameter int AUX_W      = 8,
  parameter int TRACK_RISE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [RES_W:0]    sample_value,
  output logic              dout,
  output logic              dout_oe,
  output logic              hold,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [AUX_W-1:0]  seq_reg,
  output logic [AUX_W-1:0]  range_a_reg,
  output logic [AUX_W-1:0]  range_b_reg,
  output logic [ID_W-1:0]   cur_chan
);
  localparam int FRAME_LEN = ID_W + 1 + RES_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic             ev_cs_fall, ev_cs_rise;
  logic             sclk_fall, sclk_rise;
  logic             ev_data_fall, ev_frame_done;
  logic [CNT_W-1:0] fall_idx;
  logic             dout_bit;

  sp_edge_det #(.IDLE_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .sig(cs_n), .rise(ev_cs_rise), .fall(ev_cs_fall));

  sp_edge_det #(.IDLE_VAL(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .sig(sclk), .rise(sclk_rise), .fall(sclk_fall));

  sp_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .TRACK_RISE(TRACK_RISE), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_cs_fall(ev_cs_fall), .ev_cs_rise(ev_cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .ev_data_fall(ev_data_fall),
    .ev_frame_done(ev_frame_done), .fall_idx(fall_idx), .hold(hold), .dout_oe(dout_oe));

  sp_reg_file #(.CTRL_W(CTRL_W), .AUX_W(AUX_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_cs_fall(ev_cs_fall), .ev_data_fall(ev_data_fall),
    .fall_idx(fall_idx), .din(din), .ctrl_reg(ctrl_reg), .seq_reg(seq_reg),
    .range_a_reg(range_a_reg), .range_b_reg(range_b_reg));

  sp_tx_path #(.ID_W(ID_W), .RES_W(RES_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .ev_cs_fall(ev_cs_fall), .ev_data_fall(ev_data_fall),
    .ev_frame_done(ev_frame_done), .fall_idx(fall_idx), .sample_value(sample_value),
    .dout_bit(dout_bit), .chan(cur_chan));

  assign dout = dout_bit & dout_oe;

  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout); // R4
endmodule

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din;
  logic [12:0] sample_value;
  logic        dout, dout_oe, hold;
  logic [11:0] ctrl_reg;
  logic [7:0]  seq_reg, range_a_reg, range_b_reg;
  logic [2:0]  cur_chan;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [11:0] ctrl_m;
  logic [7:0]  seq_m, ra_m, rb_m;
  logic [2:0]  chan_m;

  always #4 clk = ~clk;

  adc_serial_port u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sample_value(sample_value), .dout(dout), .dout_oe(dout_oe), .hold(hold),
    .ctrl_reg(ctrl_reg), .seq_reg(seq_reg), .range_a_reg(range_a_reg),
    .range_b_reg(range_b_reg), .cur_chan(cur_chan));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [2:0] ch, input logic [12:0] s);
    return {ch, s};
  endfunction

  function automatic logic [15:0] make_cmd(input bit wr, input logic [1:0] sel,
                                           input logic [11:0] data, input logic [15:0] filler);
    logic [15:0] w;
    w = filler;
    w[15] = wr;
    w[14:13] = sel;
    if (sel == 2'b00) w[12:1] = data;
    else              w[12:5] = data[7:0];
    return w;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    check({"R8 control ", tag}, 32'(ctrl_reg), 32'(ctrl_m));
    check({"R9 sequence ", tag}, 32'(seq_reg), 32'(seq_m));
    check({"R9 range A ", tag}, 32'(range_a_reg), 32'(ra_m));
    check({"R9 range B ", tag}, 32'(range_b_reg), 32'(rb_m));
    check({"R10 channel ", tag}, 32'(cur_chan), 32'(chan_m));
  endtask

  task automatic run_frame(input logic [15:0] cmd, input int n_falls,
                           input logic [12:0] smp, input int extra);
    logic [15:0] ef;
    ef = exp_frame(chan_m, smp);
    sample_value = smp;
    cs_n = 1'b0;
    tick();
    check("R2 output enable at start", 32'(dout_oe), 32'd1);
    check("R2 hold at start", 32'(hold), 32'd1);
    check("R2 first tag bit", 32'(dout), 32'(ef[15]));
    for (int k = 1; k <= n_falls; k++) begin
      if (k == 5) sample_value = 13'($urandom); // R12: late change must not show
      din = cmd[16-k];
      sclk = 1'b0;
      tick();
      if (k < 16) begin
        check("R3 frame bit", 32'(dout), 32'(ef[15-k]));
        check("R3 enable inside frame", 32'(dout_oe), 32'd1);
      end else begin
        check("R4 release after last edge", 32'(dout_oe), 32'd0);
        check("R4 quiet line", 32'(dout), 32'd0);
      end
      sclk = 1'b1;
      tick();
      check("R5 hold level", 32'(hold), 32'(k < 14));
    end
    for (int e = 0; e < extra; e++) begin
      din = 1'($urandom);
      sclk = 1'b0;
      tick();
      check("R11 no drive after frame", 32'(dout_oe), 32'd0);
      sclk = 1'b1;
      tick();
    end
    cs_n = 1'b1;
    tick();
    check("R6 enable off after cs rise", 32'(dout_oe), 32'd0);
    check("R6 hold off after cs rise", 32'(hold), 32'd0);
    if (cmd[15]) begin
      if (cmd[14:13] == 2'b00) begin
        if (n_falls >= 15) ctrl_m = cmd[12:1];
      end else if (n_falls >= 11) begin
        case (cmd[14:13])
          2'b01:   seq_m = cmd[12:5];
          2'b10:   ra_m  = cmd[12:5];
          default: rb_m  = cmd[12:5];
        endcase
      end
    end
    if (n_falls >= 16) chan_m = chan_m + 3'd1;
    check_regs(n_falls >= 16 ? "after full frame" : "after aborted frame");
    din = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0; sample_value = '0;
    ctrl_m = '0; seq_m = '0; ra_m = '0; rb_m = '0; chan_m = '0;
    repeat (3) tick();
    check("R1 enable after reset", 32'(dout_oe), 32'd0);
    check("R1 hold after reset", 32'(hold), 32'd0);
    check_regs("R1 reset");
    rst_n = 1'b1;
    tick();

    // R7: each select code reaches its own register
    run_frame(make_cmd(1'b1, 2'b00, 12'hA5C, 16'h0000), 16, 13'h1ABC, 0);
    run_frame(make_cmd(1'b1, 2'b01, 12'h03C, 16'hFFFF), 16, 13'h0123, 0);
    run_frame(make_cmd(1'b1, 2'b10, 12'h0C3, 16'h0000), 16, 13'h1000, 0);
    run_frame(make_cmd(1'b1, 2'b11, 12'h05A, 16'h0000), 16, 13'h0FFF, 0);
    // R7: write flag 0 changes nothing
    run_frame(make_cmd(1'b0, 2'b01, 12'h0FF, 16'h0000), 16, 13'h0001, 0);
    // R9: abort at 10 keeps, abort at 11 commits
    run_frame(make_cmd(1'b1, 2'b01, 12'h011, 16'h0000), 10, 13'h0055, 0);
    run_frame(make_cmd(1'b1, 2'b10, 12'h0EE, 16'h0000), 11, 13'h1555, 0);
    // R8: abort at 14 keeps, abort at 15 commits
    run_frame(make_cmd(1'b1, 2'b00, 12'h123, 16'h0000), 14, 13'h0AAA, 0);
    run_frame(make_cmd(1'b1, 2'b00, 12'h3C7, 16'h0000), 15, 13'h1F0F, 0);
    // R6: very early abort
    run_frame(make_cmd(1'b1, 2'b11, 12'h0AB, 16'h0000), 1, 13'h0777, 0);
    // R11: extra clocks after a full frame
    run_frame(make_cmd(1'b1, 2'b11, 12'h0F1, 16'h0000), 16, 13'h0808, 4);
    // R10: wrap of the channel counter
    for (int i = 0; i < 9; i++)
      run_frame(make_cmd(1'b0, 2'($urandom), 12'($urandom), 16'($urandom)), 16,
                13'($urandom), 0);

    for (int i = 0; i < 60; i++) begin
      int nf;
      int ex;
      nf = (($urandom % 4) == 0) ? 1 + int'($urandom % 15) : 16;
      ex = (nf == 16 && ($urandom % 3) == 0) ? 1 + int'($urandom % 3) : 0;
      run_frame(make_cmd(1'($urandom), 2'($urandom), 12'($urandom), 16'($urandom)),
                nf, 13'($urandom), ex);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule